// File: doc/BRIEF.md
# Split Load Queue Allocator

This block decides, at dispatch, where each decoded load is parked while it is in flight. Two load buffers exist side by side: a small associative queue that takes part in address searches, and a larger non-associative queue divided into equal banks that is cheap to hold entries in. Each load arrives with one prediction bit that says whether it is likely to alias an in-flight store. The allocator turns that bit and the fill levels of every buffer into a placement: the target queue, the bank (for the banked queue) and the entry slot. When no legal placement exists it raises a stall instead.

Loads predicted dependent may only live in the associative queue. Loads predicted independent prefer the banked queue. Banks are visited in round-robin order, and a full bank is skipped. When every bank is full, an independent load falls back into the associative queue, because placing it there is always safe. Each queue and each bank releases entries in allocation order: a commit pulse names the queue, the bank and the slot, and it frees that slot only if it is the oldest live entry there.

A four-state mode machine holds the fill picture for the next cycle and drives the routing outputs. Its states are:
- `ST_OPEN`: both queues have room.
- `ST_SPILL`: every bank is full and the associative queue has room.
- `ST_AQ_FULL`: the associative queue is full and at least one bank has room.
- `ST_JAMMED`: both are full.

Every cycle the machine moves to the state that matches the fill after that cycle's allocations and frees. The transitions are:
- fill banks: `ST_OPEN` to `ST_SPILL`.
- fill associative: `ST_OPEN` to `ST_AQ_FULL`.
- fill both: any state to `ST_JAMMED`.
- drain banks: `ST_SPILL` or `ST_JAMMED` to `ST_OPEN` or `ST_AQ_FULL`.
- drain associative: `ST_AQ_FULL` or `ST_JAMMED` to `ST_OPEN` or `ST_SPILL`.

Top module: `lq_split_alloc`

## Requirements
- R1: A load with `ld_dep`=1 that is accepted is always placed in the associative queue, reported as `ld_to_bnk`=0 and `ld_bank`=0.
- R2: A load with `ld_dep`=0 is placed in the banked queue (`ld_to_bnk`=1) whenever at least one bank has a free entry.
- R3: A load with `ld_dep`=0 that finds every bank full is placed in the associative queue (`ld_to_bnk`=0) when that queue has a free entry.
- R4: `ld_stall` is 1 exactly when `ld_valid` is 1 and either `ld_dep`=1 with the associative queue full, or `ld_dep`=0 with both the associative queue and every bank full. It is 0 whenever `ld_valid` is 0. A stalled load allocates nothing.
- R5: Bank choice starts at a round-robin pointer and takes the first non-full bank in ascending order, wrapping after bank NB_BANKS-1. After an allocation into bank b the pointer moves to b+1, wrapping to 0.
- R6: `ld_index` is the next slot of the chosen queue or bank. Slots are handed out 0, 1, 2 and so on, and wrap to 0 after depth-1.
- R7: A commit with `cm_valid`=1 frees an entry only when `cm_index` equals the oldest live slot of the queue selected by `cm_to_bnk` (1 = banked, with bank `cm_bank`). A commit naming another slot, an empty queue or a bank number of NB_BANKS or more changes nothing.
- R8: The occupancy of every queue and bank stays between 0 and its depth. An allocation and a free in the same queue or bank in the same cycle leave its occupancy unchanged.
- R9: After reset every queue and bank is empty, the mode is `ST_OPEN` and the round-robin pointer is at bank 0. The first independent load therefore gets bank 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A decoded load asks for a slot this cycle |
| ld_dep | input | 1 | Prediction bit: 1 = likely dependent |
| ld_stall | output | 1 | Load cannot be placed this cycle |
| ld_to_bnk | output | 1 | Placement queue: 1 = banked, 0 = associative |
| ld_bank | output | $clog2(NB_BANKS) | Chosen bank, 0 when associative |
| ld_index | output | max of slot widths | Chosen slot within queue or bank |
| cm_valid | input | 1 | Commit pulse releasing one entry |
| cm_to_bnk | input | 1 | Queue of the released entry: 1 = banked |
| cm_bank | input | $clog2(NB_BANKS) | Bank of the released entry |
| cm_index | input | max of slot widths | Slot of the released entry |

## Verification
The bench builds the allocator with an associative depth of 4, three banks and a bank depth of 2. With these values a handful of dispatches is enough to drive the block through every mode state. Full-bank skipping, the spill into the associative queue, both stall causes and slot wrap-around all come up many times in a few thousand random cycles. The three-bank setting keeps the non-power-of-two wrap of the round-robin pointer, and a `cm_bank` value of 3 that names no bank, reachable by the stimulus.

// File: rtl/lq_split_pkg.sv
package lq_split_pkg;

    // Fill picture of the two load buffers for the current cycle
    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_SPILL   = 2'd1,
        ST_AQ_FULL = 2'd2,
        ST_JAMMED  = 2'd3
    } lq_mode_e;

endpackage

// File: rtl/lq_ring.sv
// In-order slot tracker for one queue or one bank.
module lq_ring #(
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          full_next
);

    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q, cnt_d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        cnt_d = cnt_q + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= bump(tail_q);
            if (pop)  head_q <= bump(head_q);
            cnt_q <= cnt_d;
        end
    end

    assign head      = head_q;
    assign tail      = tail_q;
    assign count     = cnt_q;
    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign full_next = (cnt_d == CW'(DEPTH));

endmodule

// File: rtl/lq_bank_rr.sv
// Round-robin bank selector that skips full banks.
module lq_bank_rr #(
    parameter int NB = 3,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bank_full,
    input  logic          adv,
    output logic [BW-1:0] pick
);

    logic [BW-1:0] rr_q;

    always_comb begin
        int  idx;
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NB; k++) begin
            idx = int'(rr_q) + k;
            if (idx >= NB) idx = idx - NB;
            if (!found && !bank_full[idx]) begin
                pick  = BW'(idx);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (adv) begin
            rr_q <= (int'(pick) == NB - 1) ? '0 : pick + BW'(1);
        end
    end

endmodule

// File: rtl/lq_mode_fsm.sv
// Mode machine: tracks the fill picture and routes each load.
module lq_mode_fsm
    import lq_split_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     aq_full_nx,
    input  logic     bnk_full_nx,
    input  logic     ld_valid,
    input  logic     ld_dep,
    output logic     ld_stall,
    output logic     ld_to_bnk,
    output lq_mode_e mode_q
);

    lq_mode_e mode_d;
    logic     blocked;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ST_OPEN;
        else        mode_q <= mode_d;
    end

    // Next state: fill picture after this cycle's updates
    always_comb begin
        unique case ({aq_full_nx, bnk_full_nx})
            2'b00:   mode_d = ST_OPEN;
            2'b01:   mode_d = ST_SPILL;
            2'b10:   mode_d = ST_AQ_FULL;
            default: mode_d = ST_JAMMED;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (mode_q)
            ST_OPEN: begin
                blocked   = 1'b0;
                ld_to_bnk = !ld_dep;
            end
            ST_SPILL: begin
                blocked   = 1'b0;
                ld_to_bnk = 1'b0;
            end
            ST_AQ_FULL: begin
                blocked   = ld_dep;
                ld_to_bnk = !ld_dep;
            end
            default: begin
                blocked   = 1'b1;
                ld_to_bnk = 1'b0;
            end
        endcase
        ld_stall = ld_valid && blocked;
    end

endmodule

// File: rtl/lq_split_alloc.sv
module lq_split_alloc
    import lq_split_pkg::*;
#(
    parameter int AQ_DEPTH   = 32,
    parameter int NB_BANKS   = 3,
    parameter int BANK_DEPTH = 16,
    localparam int AQ_IW = $clog2(AQ_DEPTH),
    localparam int BK_IW = $clog2(BANK_DEPTH),
    localparam int IW    = (AQ_IW > BK_IW) ? AQ_IW : BK_IW,
    localparam int BW    = (NB_BANKS > 1) ? $clog2(NB_BANKS) : 1,
    localparam int AQ_CW = $clog2(AQ_DEPTH + 1),
    localparam int BK_CW = $clog2(BANK_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          ld_dep,
    output logic          ld_stall,
    output logic          ld_to_bnk,
    output logic [BW-1:0] ld_bank,
    output logic [IW-1:0] ld_index,
    input  logic          cm_valid,
    input  logic          cm_to_bnk,
    input  logic [BW-1:0] cm_bank,
    input  logic [IW-1:0] cm_index
);

    logic                             alloc;
    logic                             aq_push, aq_pop;
    logic [AQ_IW-1:0]                 aq_head, aq_tail;
    logic [AQ_CW-1:0]                 aq_cnt;
    logic                             aq_full, aq_empty, aq_full_nx;

    logic [NB_BANKS-1:0]              bk_push, bk_pop;
    logic [NB_BANKS-1:0][BK_IW-1:0]   bk_head, bk_tail;
    logic [NB_BANKS-1:0][BK_CW-1:0]   bk_cnt;
    logic [NB_BANKS-1:0]              bk_full, bk_empty, bk_full_nx;
    logic [BW-1:0]                    bk_pick;
    logic                             bk_adv;
    lq_mode_e                         mode_q;

    assign alloc   = ld_valid && !ld_stall;
    assign aq_push = alloc && !ld_to_bnk;
    assign bk_adv  = alloc && ld_to_bnk;
    assign aq_pop  = cm_valid && !cm_to_bnk && !aq_empty
                     && (cm_index == IW'(aq_head));

    lq_ring #(.DEPTH(AQ_DEPTH)) u_aq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (aq_push),
        .pop       (aq_pop),
        .head      (aq_head),
        .tail      (aq_tail),
        .count     (aq_cnt),
        .full      (aq_full),
        .empty     (aq_empty),
        .full_next (aq_full_nx)
    );

    for (genvar b = 0; b < NB_BANKS; b++) begin : g_bank
        assign bk_push[b] = bk_adv && (bk_pick == BW'(b));
        assign bk_pop[b]  = cm_valid && cm_to_bnk && (cm_bank == BW'(b))
                            && !bk_empty[b] && (cm_index == IW'(bk_head[b]));

        lq_ring #(.DEPTH(BANK_DEPTH)) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (bk_push[b]),
            .pop       (bk_pop[b]),
            .head      (bk_head[b]),
            .tail      (bk_tail[b]),
            .count     (bk_cnt[b]),
            .full      (bk_full[b]),
            .empty     (bk_empty[b]),
            .full_next (bk_full_nx[b])
        );
    end

    lq_bank_rr #(.NB(NB_BANKS)) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_full (bk_full),
        .adv       (bk_adv),
        .pick      (bk_pick)
    );

    lq_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .aq_full_nx  (aq_full_nx),
        .bnk_full_nx (&bk_full_nx),
        .ld_valid    (ld_valid),
        .ld_dep      (ld_dep),
        .ld_stall    (ld_stall),
        .ld_to_bnk   (ld_to_bnk),
        .mode_q      (mode_q)
    );

    assign ld_bank  = ld_to_bnk ? bk_pick : '0;
    assign ld_index = ld_to_bnk ? IW'(bk_tail[bk_pick]) : IW'(aq_tail);

endmodule

// File: rtl/lq_split_alloc_chk.sv
module lq_split_alloc_chk
    import lq_split_pkg::*;
#(
    parameter int AQ_DEPTH   = 32,
    parameter int NB_BANKS   = 3,
    parameter int BANK_DEPTH = 16,
    localparam int BW    = (NB_BANKS > 1) ? $clog2(NB_BANKS) : 1,
    localparam int AQ_CW = $clog2(AQ_DEPTH + 1),
    localparam int BK_CW = $clog2(BANK_DEPTH + 1)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ld_valid,
    input logic                           ld_dep,
    input logic                           ld_stall,
    input logic                           ld_to_bnk,
    input logic [BW-1:0]                  ld_bank,
    input logic [AQ_CW-1:0]               aq_cnt,
    input logic                           aq_full,
    input logic                           aq_push,
    input logic                           aq_pop,
    input logic [NB_BANKS-1:0]            bk_full,
    input logic [NB_BANKS-1:0][BK_CW-1:0] bk_cnt,
    input lq_mode_e                       mode_q
);

    // R1
    dep_to_assoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_dep && !ld_stall) |-> !ld_to_bnk);

    // R3
    spill_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_SPILL) |-> (&bk_full && !aq_full));

    // R4
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> (ld_valid && aq_full));

    // R5
    bank_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_stall && ld_to_bnk) |-> !bk_full[ld_bank]);

    // R8
    aq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aq_cnt <= AQ_CW'(AQ_DEPTH));

    // R8
    aq_net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aq_push && aq_pop) |=> $stable(aq_cnt));

    for (genvar b = 0; b < NB_BANKS; b++) begin : g_bk_chk
        // R8
        bk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bk_cnt[b] <= BK_CW'(BANK_DEPTH));
    end

endmodule

bind lq_split_alloc lq_split_alloc_chk #(
    .AQ_DEPTH   (AQ_DEPTH),
    .NB_BANKS   (NB_BANKS),
    .BANK_DEPTH (BANK_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_dep    (ld_dep),
    .ld_stall  (ld_stall),
    .ld_to_bnk (ld_to_bnk),
    .ld_bank   (ld_bank),
    .aq_cnt    (aq_cnt),
    .aq_full   (aq_full),
    .aq_push   (aq_push),
    .aq_pop    (aq_pop),
    .bk_full   (bk_full),
    .bk_cnt    (bk_cnt),
    .mode_q    (mode_q)
);

// File: tb/test_lq_split_alloc.sv
`timescale 1ns/1ps
module test_lq_split_alloc;

    localparam int AQD = 4;
    localparam int NB  = 3;
    localparam int BD  = 2;
    localparam int IW  = 2;
    localparam int BW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0, ld_dep = 1'b0;
    logic          ld_stall, ld_to_bnk;
    logic [BW-1:0] ld_bank;
    logic [IW-1:0] ld_index;
    logic          cm_valid = 1'b0, cm_to_bnk = 1'b0;
    logic [BW-1:0] cm_bank = '0;
    logic [IW-1:0] cm_index = '0;

    int tests = 0;
    int fails = 0;

    // Reference model state
    int aqh = 0, aqt = 0, aqc = 0, rr = 0;
    int bh[NB], bt[NB], bc[NB];

    always #2 clk = ~clk;

    lq_split_alloc #(.AQ_DEPTH(AQD), .NB_BANKS(NB), .BANK_DEPTH(BD)) i_lq_split_alloc (
        .clk, .rst_n, .ld_valid, .ld_dep, .ld_stall, .ld_to_bnk, .ld_bank, .ld_index,
        .cm_valid, .cm_to_bnk, .cm_bank, .cm_index
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    function automatic int wrap(input int p, input int d);
        return (p == d - 1) ? 0 : p + 1;
    endfunction

    task automatic step(input bit v, input bit dep, input bit cv, input bit cq,
                        input int cb, input int ci, input string note);
        bit aqf, allb, exp_stall, exp_tb, pop_aq, pop_bk;
        int pick;
        @(negedge clk);
        ld_valid = v; ld_dep = dep;
        cm_valid = cv; cm_to_bnk = cq; cm_bank = BW'(cb); cm_index = IW'(ci);
        #1;
        aqf  = (aqc == AQD);
        allb = 1'b1;
        for (int b = 0; b < NB; b++) if (bc[b] != BD) allb = 1'b0;
        pick = 0;
        for (int k = NB - 1; k >= 0; k--) begin
            int idx = (rr + k) % NB;
            if (bc[idx] != BD) pick = idx;
        end
        exp_stall = v && (dep ? aqf : (allb && aqf));
        exp_tb    = !dep && !allb;
        check((note != "") ? note : "R4", "ld_stall", int'(ld_stall), int'(exp_stall));
        if (v && !exp_stall) begin
            check(dep ? "R1" : (allb ? "R3" : "R2"), "ld_to_bnk", int'(ld_to_bnk), int'(exp_tb));
            if (exp_tb) begin
                check("R5", "ld_bank", int'(ld_bank), pick);
                check("R6", "ld_index bank", int'(ld_index), bt[pick]);
            end else begin
                check("R1", "ld_bank", int'(ld_bank), 0);
                check("R6", "ld_index assoc", int'(ld_index), aqt);
            end
        end
        pop_aq = cv && !cq && aqc > 0 && ci == aqh;
        pop_bk = cv && cq && cb < NB && cb >= 0;
        if (pop_bk) pop_bk = bc[cb] > 0 && ci == bh[cb];
        if (pop_aq) begin aqh = wrap(aqh, AQD); aqc--; end
        if (pop_bk) begin bh[cb] = wrap(bh[cb], BD); bc[cb]--; end
        if (v && !exp_stall) begin
            if (exp_tb) begin
                bt[pick] = wrap(bt[pick], BD); bc[pick]++;
                rr = (pick + 1) % NB;
            end else begin
                aqt = wrap(aqt, AQD); aqc++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        bit cq;
        int cb, ci;
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin bh[b] = 0; bt[b] = 0; bc[b] = 0; end
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R9: reset state seen at the ports
        @(negedge clk);
        ld_valid = 1'b0; #1;
        check("R9", "ld_stall idle", int'(ld_stall), 0);
        ld_valid = 1'b1; ld_dep = 1'b0; #1;
        check("R9", "ld_to_bnk", int'(ld_to_bnk), 1);
        check("R9", "ld_bank", int'(ld_bank), 0);
        check("R9", "ld_index", int'(ld_index), 0);
        ld_valid = 1'b0;

        // Fill all banks round-robin (R2, R5, R6)
        for (int i = 0; i < NB * BD; i++) step(1, 0, 0, 0, 0, 0, "");
        // Banks full: independent spills (R3), then dependents fill AQ
        step(1, 0, 0, 0, 0, 0, "");
        for (int i = 0; i < AQD - 1; i++) step(1, 1, 0, 0, 0, 0, "");
        step(1, 1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 0, 0, "R4");
        // Commit naming a non-oldest slot is ignored (R7)
        step(0, 0, 1, 0, 0, 2, "R7");
        step(1, 1, 0, 0, 0, 0, "R7");
        step(0, 0, 1, 1, 3, 0, "R7");
        step(1, 0, 0, 0, 0, 0, "R7");
        // Free bank 1 head; next independent skips full bank 0 (R5)
        step(0, 0, 1, 1, 1, 0, "");
        step(1, 0, 0, 0, 0, 0, "");
        // Alloc and free in AQ in one cycle (R8)
        step(0, 0, 1, 0, 0, 0, "");
        step(1, 1, 1, 0, 0, 1, "");
        step(1, 1, 0, 0, 0, 0, "");
        step(1, 1, 0, 0, 0, 0, "R8");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            cq = 1'($urandom_range(0, 1));
            cb = $urandom_range(0, NB);
            if ($urandom_range(0, 3) != 0)
                ci = cq ? ((cb < NB) ? bh[cb] : 0) : aqh;
            else
                ci = $urandom_range(0, 3);
            step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 2) != 0, cq, cb, ci, "");
        end

        @(negedge clk);
        ld_valid = 1'b0; cm_valid = 1'b0;
        summary();
        $finish;
    end

endmodule